// File: doc/BRIEF.md
# Three-phase complementary PWM generator

This block drives the six switches of a three-phase bridge. One up/down carrier counter is shared by all three phases. It rises from zero to a parameterised half-period count and falls back, so one switching period lasts `2*HALF_COUNT` clock cycles. Each phase compares the carrier against its own threshold to form a reference waveform centred on the carrier peak. That reference is then split into a high-side and a low-side gate signal, with a dead band between their edges.

Software writes one duty command per phase as a signed fixed-point fraction. The block clamps each command into the closed range zero to one, scales it to a carrier threshold, and stores it in a shadow register. The shadow register is loaded only in the last cycle of each period, so a period never mixes two duty settings. A one-cycle start pulse marks the first cycle of every period and can serve as a periodic interrupt.

A global enable gates all six pins low. The carrier, the stored thresholds and the dead-band state keep running while the pins are gated. The dead band shortens each side's on-time by one dead-band interval, and the block applies no correction for that loss.

Top module: `pwm3_gen`

## Requirements
- R1: `start_o` is high for exactly one cycle, and it recurs every `2*HALF_COUNT` clock cycles.
- R2: A duty command below zero is treated as 0.0. The duty input is signed, 18 bits wide, with 15 fractional bits, so 1.0 = 32768. At 0.0 the high side stays off for the whole period and the low side stays on for the whole period.
- R3: A duty command above 1.0 (32768) is treated as 1.0. At 1.0 the high side stays on for the whole period and the low side stays off for the whole period.
- R4: For a clamped duty `c`, the threshold is `t = floor(c*HALF_COUNT/32768)`. For `0 < t < HALF_COUNT`, with both reference widths longer than the dead band, the high side is on for `2t - DEAD_CYCLES` cycles per period and the low side for `2(HALF_COUNT-t) - DEAD_CYCLES` cycles.
- R5: The high-side pulse is centred on the carrier peak. Counting the start-pulse cycle as offset 0, the first high cycle is at offset `HALF_COUNT - t + DEAD_CYCLES + 3` and the first low cycle after the pulse is at offset `HALF_COUNT + t + 3`.
- R6: The two outputs of a phase are never on together. An output turns on only after its partner has been off for at least `DEAD_CYCLES` cycles.
- R7: If the reference high width `2t` is no longer than `DEAD_CYCLES`, the high side never turns on. The low side then loses only one dead band per period.
- R8: Duty inputs are sampled only in the last cycle of a period, the cycle before `start_o`. A change part-way through a period leaves that period's pulses untouched and takes effect from the next one.
- R9: One cycle after `en_i` is seen low, all six outputs are low. When `en_i` returns high, the outputs show the stored duties again.
- R10: Duty commands written while `en_i` is low are latched as usual and appear once the outputs are re-enabled.
- R11: While `rst_ni` is low, all six outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Output enable for all six gate signals |
| duty_u_i | input | 18 | Phase U duty command, signed, 15 fractional bits |
| duty_v_i | input | 18 | Phase V duty command, signed, 15 fractional bits |
| duty_w_i | input | 18 | Phase W duty command, signed, 15 fractional bits |
| start_o | output | 1 | Single-cycle pulse at the first cycle of each period |
| u_hi_o | output | 1 | Phase U high-side gate |
| u_lo_o | output | 1 | Phase U low-side gate |
| v_hi_o | output | 1 | Phase V high-side gate |
| v_lo_o | output | 1 | Phase V low-side gate |
| w_hi_o | output | 1 | Phase W high-side gate |
| w_lo_o | output | 1 | Phase W low-side gate |

## Verification
Each gate output trails the carrier by three registers: the reference flop, the dead-band flop and the output gate flop. Pulse edges therefore land three cycles later than the carrier compare alone would place them, and the edge-offset checks expect exactly that. Enable acts through the output gate flop alone, so the bench checks the pins at the first falling clock edge after it drives `en_i` low. A duty change reaches the pins only after the next period boundary. For that reason every on-time count is taken over a full period window that begins at the start-pulse cycle, after settling periods have passed, and only the shadow test counts the window in which the change is made.

// File: rtl/pwm3_pkg.sv
`timescale 1ns/1ps
package pwm3_pkg;
    localparam int NPH    = 3;
    localparam int DUTY_W = 18;
    localparam int FRAC_W = 15;

    typedef logic signed [DUTY_W-1:0] duty_t;

    localparam duty_t DUTY_ONE = duty_t'(1 << FRAC_W);
endpackage

// File: rtl/pwm3_carrier.sv
`timescale 1ns/1ps
module pwm3_carrier #(
    parameter int HALF_COUNT = 2000,
    localparam int CW = $clog2(HALF_COUNT + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    output logic [CW-1:0] cnt_o,
    output logic          down_o,
    output logic          start_o,
    output logic          last_o
);
    localparam logic [CW-1:0] TOP_C = CW'(HALF_COUNT);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          down;
    } car_st_t;

    car_st_t car_d, car_q;

    always_comb begin
        car_d = car_q;
        if (!car_q.down) begin
            if (car_q.cnt == TOP_C - ONE_C) begin
                car_d.cnt  = TOP_C;
                car_d.down = 1'b1;
            end else begin
                car_d.cnt = car_q.cnt + ONE_C;
            end
        end else begin
            if (car_q.cnt == ONE_C) begin
                car_d.cnt  = '0;
                car_d.down = 1'b0;
            end else begin
                car_d.cnt = car_q.cnt - ONE_C;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) car_q <= '0;
        else         car_q <= car_d;
    end

    assign cnt_o   = car_q.cnt;
    assign down_o  = car_q.down;
    assign start_o = !car_q.down && (car_q.cnt == '0);
    assign last_o  = car_q.down && (car_q.cnt == ONE_C);
endmodule

// File: rtl/pwm3_shadow.sv
`timescale 1ns/1ps
module pwm3_shadow import pwm3_pkg::*; #(
    parameter int HALF_COUNT = 2000,
    localparam int CW = $clog2(HALF_COUNT + 1),
    localparam int PW = FRAC_W + 1 + CW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  duty_t         duty_i,
    output logic [CW-1:0] thr_o
);
    localparam logic [FRAC_W:0] ONE_U = {1'b1, {FRAC_W{1'b0}}};

    logic [FRAC_W:0] clamped;
    logic [CW-1:0]   thr_d, thr_q;

    always_comb begin
        if (duty_i < 0)             clamped = '0;
        else if (duty_i > DUTY_ONE) clamped = ONE_U;
        else                        clamped = duty_i[FRAC_W:0];
    end

    always_comb begin
        thr_d = thr_q;
        if (load_i) thr_d = CW'((PW'(clamped) * PW'(HALF_COUNT)) >> FRAC_W);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) thr_q <= '0;
        else         thr_q <= thr_d;
    end

    assign thr_o = thr_q;
endmodule

// File: rtl/pwm3_deadband.sv
`timescale 1ns/1ps
module pwm3_deadband #(
    parameter int DEAD_CYCLES = 192,
    localparam int TW = $clog2(DEAD_CYCLES + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    output logic hs_o,
    output logic ls_o
);
    localparam logic [TW-1:0] DT_C = TW'(DEAD_CYCLES);

    typedef struct packed {
        logic          prev;
        logic [TW-1:0] tmr;
        logic          hs;
        logic          ls;
    } db_st_t;

    db_st_t db_d, db_q;

    always_comb begin
        db_d      = db_q;
        db_d.prev = ref_i;
        if (ref_i != db_q.prev)  db_d.tmr = '0;
        else if (db_q.tmr != DT_C) db_d.tmr = db_q.tmr + TW'(1);
        db_d.hs = ref_i  && (db_d.tmr == DT_C);
        db_d.ls = !ref_i && (db_d.tmr == DT_C);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) db_q <= '0;
        else         db_q <= db_d;
    end

    assign hs_o = db_q.hs;
    assign ls_o = db_q.ls;
endmodule

// File: rtl/pwm3_gen.sv
`timescale 1ns/1ps
module pwm3_gen import pwm3_pkg::*; #(
    parameter int HALF_COUNT  = 2000,
    parameter int DEAD_CYCLES = 192
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     en_i,
    input  logic signed [DUTY_W-1:0] duty_u_i,
    input  logic signed [DUTY_W-1:0] duty_v_i,
    input  logic signed [DUTY_W-1:0] duty_w_i,
    output logic                     start_o,
    output logic                     u_hi_o,
    output logic                     u_lo_o,
    output logic                     v_hi_o,
    output logic                     v_lo_o,
    output logic                     w_hi_o,
    output logic                     w_lo_o
);
    localparam int CW = $clog2(HALF_COUNT + 1);
    localparam logic [CW-1:0] TOP_C = CW'(HALF_COUNT);

    typedef struct packed {
        logic [NPH-1:0]   refv;
        logic [2*NPH-1:0] outv;
    } gen_st_t;

    gen_st_t gen_d, gen_q;

    logic [CW-1:0] cnt;
    logic          down, last;
    duty_t         duty_a [NPH];
    logic [CW-1:0] thr    [NPH];
    logic [NPH-1:0] hs, ls;

    assign duty_a[0] = duty_u_i;
    assign duty_a[1] = duty_v_i;
    assign duty_a[2] = duty_w_i;

    pwm3_carrier #(.HALF_COUNT(HALF_COUNT)) i_carrier (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cnt_o   (cnt),
        .down_o  (down),
        .start_o (start_o),
        .last_o  (last)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        pwm3_shadow #(.HALF_COUNT(HALF_COUNT)) i_shadow (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .load_i (last),
            .duty_i (duty_a[p]),
            .thr_o  (thr[p])
        );
        pwm3_deadband #(.DEAD_CYCLES(DEAD_CYCLES)) i_deadband (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .ref_i  (gen_q.refv[p]),
            .hs_o   (hs[p]),
            .ls_o   (ls[p])
        );
    end

    always_comb begin
        gen_d = gen_q;
        for (int p = 0; p < NPH; p++) begin
            if (down) gen_d.refv[p] = cnt >  (TOP_C - thr[p]);
            else      gen_d.refv[p] = cnt >= (TOP_C - thr[p]);
            gen_d.outv[2*p]   = en_i && hs[p];
            gen_d.outv[2*p+1] = en_i && ls[p];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gen_q <= '0;
        else         gen_q <= gen_d;
    end

    assign u_hi_o = gen_q.outv[0];
    assign u_lo_o = gen_q.outv[1];
    assign v_hi_o = gen_q.outv[2];
    assign v_lo_o = gen_q.outv[3];
    assign w_hi_o = gen_q.outv[4];
    assign w_lo_o = gen_q.outv[5];
endmodule

// File: rtl/pwm3_gen_chk.sv
`timescale 1ns/1ps
module pwm3_gen_chk #(
    parameter int HALF_COUNT  = 2000,
    parameter int DEAD_CYCLES = 192
) (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic start_o,
    input logic u_hi_o,
    input logic u_lo_o,
    input logic v_hi_o,
    input logic v_lo_o,
    input logic w_hi_o,
    input logic w_lo_o
);
    localparam int PER = 2 * HALF_COUNT;

    logic [2:0] hi_v, lo_v;
    assign hi_v = {w_hi_o, v_hi_o, u_hi_o};
    assign lo_v = {w_lo_o, v_lo_o, u_lo_o};

    int unsigned since_start;
    logic        seen_start;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_start <= 0;
            seen_start  <= 1'b0;
        end else if (start_o) begin
            since_start <= 0;
            seen_start  <= 1'b1;
        end else begin
            since_start <= since_start + 1;
        end
    end

    p_period_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_o && seen_start) |-> (since_start == PER - 1));

    p_pulse_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);

    p_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (hi_v == 3'b000 && lo_v == 3'b000));

    for (genvar p = 0; p < 3; p++) begin : g_ph
        int unsigned hi_idle, lo_idle;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                hi_idle <= DEAD_CYCLES;
                lo_idle <= DEAD_CYCLES;
            end else begin
                hi_idle <= hi_v[p] ? 0 : ((hi_idle < DEAD_CYCLES) ? hi_idle + 1 : hi_idle);
                lo_idle <= lo_v[p] ? 0 : ((lo_idle < DEAD_CYCLES) ? lo_idle + 1 : lo_idle);
            end
        end

        p_no_overlap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(hi_v[p] && lo_v[p]));

        p_hi_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(hi_v[p]) |-> (lo_idle >= DEAD_CYCLES));

        p_lo_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(lo_v[p]) |-> (hi_idle >= DEAD_CYCLES));
    end
endmodule

bind pwm3_gen pwm3_gen_chk #(
    .HALF_COUNT  (HALF_COUNT),
    .DEAD_CYCLES (DEAD_CYCLES)
) i_pwm3_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .start_o (start_o),
    .u_hi_o  (u_hi_o),
    .u_lo_o  (u_lo_o),
    .v_hi_o  (v_hi_o),
    .v_lo_o  (v_lo_o),
    .w_hi_o  (w_hi_o),
    .w_lo_o  (w_lo_o)
);

// File: tb/test_pwm3_gen.sv
`timescale 1ns/1ps
module test_pwm3_gen;
    import pwm3_pkg::*;

    localparam int HALF = 100;
    localparam int DT   = 8;
    localparam int PER  = 2 * HALF;

    logic  clk = 1'b0;
    logic  rst_n = 1'b0;
    logic  en = 1'b1;
    duty_t du = '0, dv = '0, dw = '0;
    logic  start, uh, ul, vh, vl, wh, wl;

    int checks = 0, failures = 0, overlaps = 0;
    logic done = 1'b0;

    int hi_n [3];
    int lo_n [3];
    int rise_off, fall_off;

    always #2.5 clk = ~clk;

    pwm3_gen #(.HALF_COUNT(HALF), .DEAD_CYCLES(DT)) i_pwm3_gen (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en),
        .duty_u_i(du), .duty_v_i(dv), .duty_w_i(dw),
        .start_o(start),
        .u_hi_o(uh), .u_lo_o(ul), .v_hi_o(vh), .v_lo_o(vl), .w_hi_o(wh), .w_lo_o(wl)
    );

    always @(negedge clk) if (rst_n && ((uh && ul) || (vh && vl) || (wh && wl))) overlaps++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe();
        while (!start) @(negedge clk);
    endtask

    task automatic wait_periods(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wait_strobe();
        end
    endtask

    // Counts on-cycles over one period starting at the start-pulse cycle.
    task automatic measure(input int chg_at = -1, input duty_t chg_val = '0);
        logic prev;
        wait_strobe();
        for (int k = 0; k < 3; k++) begin hi_n[k] = 0; lo_n[k] = 0; end
        rise_off = -1; fall_off = -1; prev = uh;
        for (int j = 0; j < PER; j++) begin
            if (j == chg_at) du = chg_val;
            hi_n[0] += int'(uh); lo_n[0] += int'(ul);
            hi_n[1] += int'(vh); lo_n[1] += int'(vl);
            hi_n[2] += int'(wh); lo_n[2] += int'(wl);
            if (uh && !prev) rise_off = j;
            if (!uh && prev) fall_off = j;
            prev = uh;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R11 outputs low in reset", int'({uh, ul, vh, vl, wh, wl}), 0);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_period();
        int gap, width;
        wait_periods(1);
        gap = 0;
        @(negedge clk);
        width = 1;
        while (start) begin width++; @(negedge clk); end
        gap = width;
        while (!start) begin gap++; @(negedge clk); end
        check("R1 start pulse width", width, 1);
        check("R1 start pulse spacing", gap, PER);
    endtask

    task automatic t_duty_mix();
        du = 18'sd8192; dv = 18'sd16384; dw = 18'sd24576;
        wait_periods(3);
        measure();
        check("R4 U hi on-time 0.25", hi_n[0], 42);
        check("R4 U lo on-time 0.25", lo_n[0], 142);
        check("R4 V hi on-time 0.5",  hi_n[1], 92);
        check("R4 W hi on-time 0.75", hi_n[2], 142);
        check("R4 W lo on-time 0.75", lo_n[2], 42);
        check("R6 V both-off cycles", PER - hi_n[1] - lo_n[1], 2 * DT);
        check("R5 U rise offset", rise_off, HALF - 25 + DT + 3);
        check("R5 U fall offset", fall_off, HALF + 25 + 3);
    endtask

    task automatic t_clamp();
        du = -18'sd9830; dv = 18'sd49152; dw = 18'sd32768;
        wait_periods(3);
        measure();
        check("R2 negative duty hi", hi_n[0], 0);
        check("R2 negative duty lo", lo_n[0], PER);
        check("R3 above-unity duty hi", hi_n[1], PER);
        check("R3 above-unity duty lo", lo_n[1], 0);
        check("R3 unity duty hi", hi_n[2], PER);
    endtask

    task automatic t_narrow();
        du = 18'sd983;
        wait_periods(3);
        measure();
        check("R7 narrow pulse suppressed hi", hi_n[0], 0);
        check("R7 narrow pulse lo", lo_n[0], PER - 4 - DT);
    endtask

    task automatic t_shadow();
        du = 18'sd16384;
        wait_periods(3);
        measure(10, 18'sd8192);
        check("R8 mid-period change ignored", hi_n[0], 92);
        check("R8 old duty rise offset", rise_off, HALF - 50 + DT + 3);
        measure();
        check("R8 change applied next period", hi_n[0], 42);
    endtask

    task automatic t_enable();
        du = 18'sd16384;
        wait_periods(3);
        @(negedge clk) en = 1'b0;
        @(negedge clk);
        check("R9 gated next cycle", int'({uh, ul, vh, vl, wh, wl}), 0);
        measure();
        check("R9 gated period U", hi_n[0] + lo_n[0], 0);
        check("R9 gated period V W", hi_n[1] + lo_n[1] + hi_n[2] + lo_n[2], 0);
        @(negedge clk) en = 1'b1;
        wait_periods(1);
        measure();
        check("R9 stored duty resumes", hi_n[0], 92);
        @(negedge clk) en = 1'b0;
        du = 18'sd8192;
        wait_periods(3);
        @(negedge clk) en = 1'b1;
        wait_periods(1);
        measure();
        check("R10 duty written while gated hi", hi_n[0], 42);
        check("R10 duty written while gated lo", lo_n[0], 142);
    endtask

    initial begin
        t_reset();
        t_period();
        t_duty_mix();
        t_clamp();
        t_narrow();
        t_shadow();
        t_enable();
        check("R6 no overlap seen", overlaps, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule